// File: doc/BRIEF.md
# Indexed Saturating Rounding Multiply-Subtract Lane Array

This block is a single-cycle SIMD datapath. It takes three vectors of `VLEN` bits: an accumulator, a multiplicand source and an indexed source. It treats them as packed signed two's-complement elements of 16, 32 or 64 bits, and the width is chosen on every request.

The vector is divided into 128-bit segments. In each segment, one lane of the indexed source is picked by a run-time lane index and used for every element of that segment. For each element the block works out the following, at full precision:

- the accumulator element scaled up by the element width;
- minus twice the product of the multiplicand element and the picked element;
- plus half of one unit of the result.

It then keeps the upper half of that value and clamps it to the signed range of the element.

A request is presented with `in_vld`. The whole result vector is registered once and appears with `out_vld` on the next clock. The result register keeps its last value between requests. The reset `rst_n` is asynchronous and active-low, and it is expected to be released synchronously to `clk` by the reset tree that drives it.

Top module: `lane_rdmsub_array`

## Requirements
- R1: `size_sel` sets the element width: code 0 is 16 bits, code 1 is 32 bits, and codes 2 and 3 are both 64 bits. Element e occupies bits [e·w+w−1 : e·w] of every vector.
- R2: Only the low bits of `lane_idx` that the width needs are used: bits [2:0] for 16-bit, bits [1:0] for 32-bit and bit [0] for 64-bit. Higher index bits have no effect on the result.
- R3: For element e, the picked element of `src_b` is lane (e − (e mod L)) + idx, where L = 128/w. Each 128-bit segment therefore uses its own lane at the same relative position.
- R4: For each element, the result is the value floor((acc·2^w − 2·a·b + 2^(w−1)) / 2^w), after the clamping of R5, with all operands signed.
- R5: The result clamps to 2^(w−1)−1 above and to −2^(w−1) below. This includes the case where every operand is the most negative value.
- R6: Rounding is to nearest with halves going upward: a product that lands exactly on a half step rounds toward +∞.
- R7: `out_vld` is high in the cycle after each clock edge that samples `in_vld` high, and is low otherwise. The matching result is on `out_vec` in that same cycle.
- R8: While `in_vld` is low, `out_vec` holds its last result, whatever the data inputs do.
- R9: `out_vld` goes low as soon as `rst_n` goes low, with no clock needed, and stays low while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Request strobe |
| size_sel | input | 2 | Element width code (0: 16, 1: 32, 2/3: 64) |
| lane_idx | input | 3 | Lane index inside each 128-bit segment |
| acc_vec | input | VLEN | Accumulator vector |
| src_a | input | VLEN | Multiplicand vector |
| src_b | input | VLEN | Indexed source vector |
| out_vld | output | 1 | Result valid, one cycle after the request |
| out_vec | output | VLEN | Registered result vector |

## Verification
The bench drives every width with every index value from 0 to 7, including indices past the width's range. A design that decodes too many index bits, or that takes the lane from segment 0 instead of the local segment, then returns wrong elements in the upper segment.

Vectors filled with extreme values test both clamp directions and the case where every operand is the most negative value. There a lane that is too narrow wraps instead of clamping. Operands placed exactly on half steps catch rounding toward zero, or a wrong rounding constant.

Idle cycles with changing data, a reset that lands mid-cycle, and width code 3 expose a result register that is not held, a valid flag that is reset synchronously, and a missing alias for code 3.

// File: rtl/rdmsub_pkg.sv
package rdmsub_pkg;
  localparam int SEG_BITS = 128;

  typedef enum logic [1:0] {
    ESZ_16  = 2'd0,
    ESZ_32  = 2'd1,
    ESZ_64  = 2'd2,
    ESZ_64B = 2'd3
  } esz_e;
endpackage

// File: rtl/rdmsub_bcast.sv
// Per-segment broadcast of one indexed lane of the second source.
module rdmsub_bcast #(
  parameter int VLEN = 256,
  parameter int ESZ  = 16
) (
  input  logic [VLEN-1:0]                                 src_b,
  input  logic [$clog2(rdmsub_pkg::SEG_BITS/ESZ)-1:0]     idx,
  output logic [VLEN-1:0]                                 bsel
);
  localparam int LPS = rdmsub_pkg::SEG_BITS / ESZ;
  localparam int NEL = VLEN / ESZ;

  for (genvar e = 0; e < NEL; e++) begin : g_el
    localparam int BASE = (e / LPS) * LPS;
    assign bsel[e*ESZ +: ESZ] = src_b[(BASE + int'(idx))*ESZ +: ESZ];
  end
endmodule

// File: rtl/rdmsub_lane.sv
// One element: (acc<<ESZ) - 2ab, rounded, high half, clamped.
module rdmsub_lane #(
  parameter int ESZ = 16
) (
  input  logic [ESZ-1:0] acc,
  input  logic [ESZ-1:0] a,
  input  logic [ESZ-1:0] b,
  output logic [ESZ-1:0] res
);
  localparam int W = 2*ESZ + 3;
  localparam logic signed [W-1:0] RND = {{(ESZ+3){1'b0}}, 1'b1, {(ESZ-1){1'b0}}};
  localparam logic [ESZ-1:0] VMIN = {1'b1, {(ESZ-1){1'b0}}};
  localparam logic [ESZ-1:0] VMAX = {1'b0, {(ESZ-1){1'b1}}};

  logic signed [2*ESZ-1:0] prod;
  logic signed [W-1:0]     acc_w, dbl_w, shr_w;
  logic                    fits;

  always_comb begin
    prod  = $signed(a) * $signed(b);
    acc_w = {{3{acc[ESZ-1]}}, acc, {ESZ{1'b0}}};
    dbl_w = {{2{prod[2*ESZ-1]}}, prod, 1'b0};
    shr_w = (acc_w - dbl_w + RND) >>> ESZ;
    fits  = (&shr_w[W-1:ESZ-1]) | ~(|shr_w[W-1:ESZ-1]);
    if (fits)          res = shr_w[ESZ-1:0];
    else if (shr_w[W-1]) res = VMIN;
    else               res = VMAX;
  end

  // R4: a zero product leaves the accumulator unchanged
  always_comb begin
    if (a == '0 || b == '0) a_r4_zero_prod: assert (res == acc);
  end

  // R5: subtracting a positive product from the floor stays at the floor
  always_comb begin
    if (acc == VMIN && prod > 0) a_r5_floor: assert (res == VMIN);
  end

  // R5: adding a positive amount to the ceiling stays at the ceiling
  always_comb begin
    if (acc == VMAX && prod < 0) a_r5_ceil: assert (res == VMAX);
  end
endmodule

// File: rtl/lane_rdmsub_array.sv
module lane_rdmsub_array
  import rdmsub_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [1:0]      size_sel,
  input  logic [2:0]      lane_idx,
  input  logic [VLEN-1:0] acc_vec,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  output logic            out_vld,
  output logic [VLEN-1:0] out_vec
);
  localparam int NW = 3;

  logic [VLEN-1:0] res_w [NW];
  logic [VLEN-1:0] vec_d, vec_q;
  logic            vld_d, vld_q;

  for (genvar gw = 0; gw < NW; gw++) begin : g_w
    localparam int EW  = 16 << gw;
    localparam int NEL = VLEN / EW;
    localparam int IB  = $clog2(SEG_BITS / EW);

    logic [VLEN-1:0] bsel, wres;

    rdmsub_bcast #(.VLEN(VLEN), .ESZ(EW)) u_bcast (
      .src_b (src_b),
      .idx   (lane_idx[IB-1:0]),
      .bsel  (bsel)
    );

    for (genvar e = 0; e < NEL; e++) begin : g_lane
      rdmsub_lane #(.ESZ(EW)) u_lane (
        .acc (acc_vec[e*EW +: EW]),
        .a   (src_a[e*EW +: EW]),
        .b   (bsel[e*EW +: EW]),
        .res (wres[e*EW +: EW])
      );
    end

    assign res_w[gw] = wres;
  end

  // next-state
  always_comb begin
    vld_d = in_vld;
    case (esz_e'(size_sel))
      ESZ_16:  vec_d = res_w[0];
      ESZ_32:  vec_d = res_w[1];
      default: vec_d = res_w[2];
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (in_vld) vec_q <= vec_d;
  end

  assign out_vld = vld_q;
  assign out_vec = vec_q;

  a_r7_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !in_vld) |=> $stable(out_vec));
endmodule

// File: tb/tb_lane_rdmsub_array.sv
`timescale 1ns/1ps
module tb_lane_rdmsub_array;
  localparam int VL = 256;

  logic          clk, rst_n, in_vld;
  logic [1:0]    size_sel;
  logic [2:0]    lane_idx;
  logic [VL-1:0] acc_vec, src_a, src_b, out_vec;
  logic          out_vld;

  int n_chk = 0, n_bad = 0;
  logic          exp_vld = 1'b0;
  logic [VL-1:0] exp_vec = '0;
  bit            have_vec = 1'b0;

  lane_rdmsub_array dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .size_sel(size_sel),
    .lane_idx(lane_idx), .acc_vec(acc_vec), .src_a(src_a), .src_b(src_b),
    .out_vld(out_vld), .out_vec(out_vec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int wid(logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 32 : 64;
  endfunction

  function automatic logic [63:0] msk(int w);
    return (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic signed [159:0] sx(logic [63:0] f, int w);
    logic signed [159:0] t;
    t = {96'b0, f};
    t = t <<< (160 - w);
    return t >>> (160 - w);
  endfunction

  function automatic logic [63:0] one_el(logic [63:0] fa, logic [63:0] fx, logic [63:0] fy, int w);
    logic signed [159:0] r, mx, mn;
    r  = (sx(fa, w) <<< w) - 2 * sx(fx, w) * sx(fy, w) + (160'sd1 <<< (w - 1));
    r  = r >>> w;
    mx = (160'sd1 <<< (w - 1)) - 160'sd1;
    mn = -(160'sd1 <<< (w - 1));
    if (r > mx) r = mx;
    if (r < mn) r = mn;
    return 64'(r) & msk(w);
  endfunction

  function automatic logic [VL-1:0] model(logic [VL-1:0] ac, logic [VL-1:0] va,
                                           logic [VL-1:0] vb, logic [1:0] s, logic [2:0] ix);
    logic [VL-1:0] res;
    int w, lps, im, sl;
    w   = wid(s);
    lps = 128 / w;
    im  = int'(ix) % lps;
    res = '0;
    for (int e = 0; e < VL / w; e++) begin
      sl  = e - (e % lps) + im;
      res = res | (VL'(one_el(64'(ac >> (e*w)) & msk(w), 64'(va >> (e*w)) & msk(w),
                              64'(vb >> (sl*w)) & msk(w), w)) << (e*w));
    end
    return res;
  endfunction

  function automatic logic [VL-1:0] rvec();
    logic [VL-1:0] r;
    for (int i = 0; i < VL/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [VL-1:0] fill(logic [63:0] v, int w);
    logic [VL-1:0] r;
    r = '0;
    for (int e = 0; e < VL / w; e++) r = r | (VL'(v & msk(w)) << (e*w));
    return r;
  endfunction

  task automatic check_now(string tag);
    n_chk++;
    if (out_vld !== exp_vld) begin
      n_bad++;
      $display("FAIL R7 out_vld act=%0b exp=%0b (%s)", out_vld, exp_vld, tag);
    end
    if (have_vec) begin
      n_chk++;
      if (out_vec !== exp_vec) begin
        n_bad++;
        $display("FAIL %s out_vec act=%h exp=%h", tag, out_vec, exp_vec);
      end
    end
  endtask

  // called at a falling edge; drives, clocks once, checks at next falling edge
  task automatic step(bit v, logic [1:0] s, logic [2:0] ix, logic [VL-1:0] ac,
                      logic [VL-1:0] va, logic [VL-1:0] vb, string tag);
    in_vld = v; size_sel = s; lane_idx = ix; acc_vec = ac; src_a = va; src_b = vb;
    if (v) begin
      exp_vec  = model(ac, va, vb, s, ix);
      have_vec = 1'b1;
    end
    exp_vld = v;
    @(posedge clk);
    @(negedge clk);
    check_now(tag);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] mn, mx;
    int w;
    rst_n = 1'b0; in_vld = 1'b0; size_sel = '0; lane_idx = '0;
    acc_vec = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 out_vld in reset act=%0b exp=0", out_vld);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R2: every width, every index including out-of-range ones
    for (int s = 0; s < 3; s++)
      for (int ix = 0; ix < 8; ix++)
        step(1'b1, 2'(s), 3'(ix), rvec(), rvec(), rvec(),
             (ix < 128 / wid(2'(s))) ? "R3" : "R2");

    // R8: idle cycles with new data keep the last result
    for (int k = 0; k < 3; k++) step(1'b0, 2'(k), 3'(k), rvec(), rvec(), rvec(), "R8");

    // R5: clamping corners per width
    for (int s = 0; s < 3; s++) begin
      w  = wid(2'(s));
      mn = 64'd1 << (w - 1);
      mx = mn - 64'd1;
      step(1'b1, 2'(s), 3'd0, fill(mn, w), fill(mn, w), fill(mn, w), "R5");
      step(1'b1, 2'(s), 3'd1, fill(mx, w), fill(mn, w), fill(mx, w), "R5");
      step(1'b1, 2'(s), 3'd0, fill(64'd0, w), fill(mn, w), fill(mn, w), "R5");
      step(1'b1, 2'(s), 3'd1, fill(mx, w), fill(mx, w), fill(mn, w), "R5");
    end

    // R6: exact half steps on 16-bit lanes (acc 0, a 1)
    step(1'b1, 2'd0, 3'd0, '0, fill(64'd1, 16), fill(64'h4000, 16), "R6");
    step(1'b1, 2'd0, 3'd0, '0, fill(64'd1, 16), fill(64'h4001, 16), "R6");
    step(1'b1, 2'd0, 3'd0, '0, fill(64'd1, 16), fill(64'hC000, 16), "R6");
    step(1'b1, 2'd0, 3'd0, '0, fill(64'd1, 16), fill(64'hBFFF, 16), "R6");
    step(1'b1, 2'd1, 3'd2, fill(64'd7, 32), fill(64'd1, 32), fill(64'h4000_0000, 32), "R6");

    // R1: code 3 behaves as 64-bit
    for (int k = 0; k < 4; k++) step(1'b1, 2'd3, 3'(k), rvec(), rvec(), rvec(), "R1");

    // R9: reset landing mid-cycle clears valid without a clock edge
    step(1'b1, 2'd1, 3'd3, rvec(), rvec(), rvec(), "R4");
    #2 rst_n = 1'b0;
    #1;
    n_chk++;
    if (out_vld !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 async clear act=%0b exp=0", out_vld);
    end
    @(negedge clk);
    rst_n = 1'b1;
    exp_vld = 1'b0;
    step(1'b0, 2'd0, 3'd0, rvec(), rvec(), rvec(), "R8");

    // R4: random traffic with idle gaps
    for (int k = 0; k < 160; k++)
      step(($urandom % 4) != 0, 2'($urandom), 3'($urandom), rvec(), rvec(), rvec(), "R4");

    finish_run();
  end
endmodule